// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block ranks the interrupt sources of one UART channel and presents the winner as a read-only status byte. It also drives an active-low interrupt-pending flag. Four sources arrive as levels and are owned by other registers: line status error, receive data ready, receive timeout and modem status change. The block does not clear those. Four further sources are latched inside the block, and each has its own clear rule. These are the transmit-holding-empty event, the flow-control (Xon/Xoff) character match, the special-character match, and a rising edge on any monitored handshake line (CTS/RTS).

The status byte is formed combinationally from the level inputs and the latched flags. A read strobe marks the cycle in which software reads the byte. Any clear caused by that read lands on the clock edge that samples the strobe, so the value returned by the read still shows the source. The flow-control, special-character and handshake sources exist only while the enhanced-features enable is set. The top two bits of the byte mirror the FIFO enable.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no source active and the FIFOs disabled, the status byte reads 0x01 and the interrupt-pending output is 1.
- R2: Exactly one source is reported: the highest-ranked active one, with the result in bits 5:0. The ranking, highest first, is:
  - line error 0x06
  - receive data ready 0x04
  - receive timeout 0x0C
  - transmit holding empty 0x02
  - modem status 0x00
  - flow-control or special character 0x10
  - handshake rising edge 0x20
  - none 0x01
- R3: Bits 7:6 read 11 while the FIFO enable is 1 and 00 while it is 0.
- R4: While the enhanced enable is 0, bits 5:4 read 0. Flow-control, special-character and handshake events arriving in that state are not latched, so they remain unreported after the enable returns to 1.
- R5: A transmit-holding-empty event latches a flag. A read clears it only when 0x02 is the value reported in that read. A read that reports a higher source leaves the flag set.
- R6: A flow-control match latches a flag that is cleared by a read reporting 0x10.
- R7: A special-character match latches a flag that is cleared by a read reporting 0x10, or by the new-character strobe.
- R8: A 0-to-1 change on any monitored handshake line sets a sticky flag, and a 1-to-0 change does not. The flag is cleared by a read reporting 0x20. After reset, the previous levels are taken as all ones.
- R9: The interrupt-pending output equals bit 0 of the status byte. It is 0 whenever any source is reported.
- R10: An event that sets a flag in the same cycle as a clear of that flag wins, and the flag stays set.
- R11: A read-caused clear takes effect on the clock edge that samples the read strobe. The byte seen during the read cycle still shows the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineErr | input | 1 | Receive line status error (level) |
| rxReady | input | 1 | Receive data ready (level) |
| rxTimeout | input | 1 | Receive timeout (level) |
| thrEmptyEvt | input | 1 | Transmit holding register became empty (pulse) |
| modemChg | input | 1 | Modem status change (level) |
| flowMatch | input | 1 | Xon/Xoff character matched (pulse) |
| specMatch | input | 1 | Special character matched (pulse) |
| hsLevel | input | NUM_HS | Monitored handshake line levels |
| rxCharStrobe | input | 1 | A new character was received (pulse) |
| fifoEn | input | 1 | FIFOs enabled |
| enhEn | input | 1 | Enhanced-features enable |
| rdStrobe | input | 1 | Status byte is being read this cycle |
| statusByte | output | 8 | Encoded interrupt status |
| intPendN | output | 1 | Interrupt pending, active low |

## Verification
A latched flag that is wrongly set shows up in the status byte in the very next cycle, provided no higher-ranked level source hides it. A flag that fails to clear shows up the same way. For that reason the stimulus keeps the higher-ranked sources quiet for much of the time. A wrong clear decision appears one edge after the read, as a code that lingers or vanishes. A masked flag wrongly latched while the enhanced enable was 0 appears as soon as the enable returns. Every cycle compares the full byte and the pending flag against a bench model, so such faults are caught within a cycle of becoming visible.

// File: rtl/uii_pkg.sv
package uii_pkg;

  typedef enum logic [2:0] {
    SRC_LINE, SRC_RXRDY, SRC_RXTO, SRC_THR,
    SRC_MODEM, SRC_FLOW, SRC_HS, SRC_NONE
  } src_e;

  // Clear strobes from control to the flag datapath
  typedef struct packed {
    logic clrThr;
    logic clrFlow;
    logic clrHs;
  } clr_t;

  function automatic logic [5:0] srcCode(src_e s);
    case (s)
      SRC_LINE:  return 6'h06;
      SRC_RXRDY: return 6'h04;
      SRC_RXTO:  return 6'h0C;
      SRC_THR:   return 6'h02;
      SRC_MODEM: return 6'h00;
      SRC_FLOW:  return 6'h10;
      SRC_HS:    return 6'h20;
      default:   return 6'h01;
    endcase
  endfunction

endpackage

// File: rtl/uii_flags.sv
module uii_flags
  import uii_pkg::*;
#(
  parameter int NUM_HS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enhEn,
  input  logic              thrEmptyEvt,
  input  logic              flowMatch,
  input  logic              specMatch,
  input  logic              rxCharStrobe,
  input  logic [NUM_HS-1:0] hsLevel,
  input  clr_t              clr,
  output logic              thrFlag,
  output logic              flowPend,
  output logic              hsFlag
);

  logic [NUM_HS-1:0] hsPrev;
  logic [NUM_HS-1:0] hsRise;
  logic              flowFlag;
  logic              specFlag;

  // One edge detector per monitored handshake line
  for (genvar g = 0; g < NUM_HS; g++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hsPrev[g] <= 1'b1;
      else       hsPrev[g] <= hsLevel[g];
    end
    assign hsRise[g] = hsLevel[g] & ~hsPrev[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrFlag  <= 1'b0;
      flowFlag <= 1'b0;
      specFlag <= 1'b0;
      hsFlag   <= 1'b0;
    end else begin
      thrFlag  <= thrEmptyEvt | (thrFlag & ~clr.clrThr);
      flowFlag <= (enhEn & flowMatch) | (flowFlag & ~clr.clrFlow);
      specFlag <= (enhEn & specMatch) | (specFlag & ~clr.clrFlow & ~rxCharStrobe);
      hsFlag   <= (enhEn & (|hsRise)) | (hsFlag & ~clr.clrHs);
    end
  end

  assign flowPend = flowFlag | specFlag;

  // R5
  thr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clr.clrThr && !thrEmptyEvt) |=> !thrFlag);
  // R11
  clr_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr.clrThr |-> thrFlag);
  // R7
  spec_char_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCharStrobe && !specMatch) |=> !specFlag);
  // R8
  hs_rise_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enhEn && (|(hsLevel & ~hsPrev))) |=> hsFlag);
  // R4
  enh_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enhEn && !flowFlag && !specFlag) |=> !flowPend);

endmodule

// File: rtl/uii_ctrl.sv
module uii_ctrl
  import uii_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineErr,
  input  logic       rxReady,
  input  logic       rxTimeout,
  input  logic       modemChg,
  input  logic       thrFlag,
  input  logic       flowPend,
  input  logic       hsFlag,
  input  logic       enhEn,
  input  logic       fifoEn,
  input  logic       rdStrobe,
  output logic [7:0] statusByte,
  output logic       intPendN,
  output clr_t       clr
);

  src_e winner;

  always_comb begin
    if (lineErr)                winner = SRC_LINE;
    else if (rxReady)           winner = SRC_RXRDY;
    else if (rxTimeout)         winner = SRC_RXTO;
    else if (thrFlag)           winner = SRC_THR;
    else if (modemChg)          winner = SRC_MODEM;
    else if (enhEn && flowPend) winner = SRC_FLOW;
    else if (enhEn && hsFlag)   winner = SRC_HS;
    else                        winner = SRC_NONE;
  end

  always_comb begin
    statusByte = {{2{fifoEn}}, srcCode(winner)};
    intPendN   = statusByte[0];
    clr.clrThr  = rdStrobe && (winner == SRC_THR);
    clr.clrFlow = rdStrobe && (winner == SRC_FLOW);
    clr.clrHs   = rdStrobe && (winner == SRC_HS);
  end

  // R2
  line_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineErr |-> (statusByte[5:0] == 6'h06));
  // R3
  fifo_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7:6] == {2{fifoEn}});
  // R4
  enh_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enhEn |-> (statusByte[5:4] == 2'b00));
  // R9
  pend_any_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineErr || rxReady || rxTimeout || modemChg || thrFlag) |-> !intPendN);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uii_pkg::*;
#(
  parameter int NUM_HS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineErr,
  input  logic              rxReady,
  input  logic              rxTimeout,
  input  logic              thrEmptyEvt,
  input  logic              modemChg,
  input  logic              flowMatch,
  input  logic              specMatch,
  input  logic [NUM_HS-1:0] hsLevel,
  input  logic              rxCharStrobe,
  input  logic              fifoEn,
  input  logic              enhEn,
  input  logic              rdStrobe,
  output logic [7:0]        statusByte,
  output logic              intPendN
);

  clr_t clr;
  logic thrFlag;
  logic flowPend;
  logic hsFlag;

  uii_flags #(.NUM_HS(NUM_HS)) u_flags (
    .clk          (clk),
    .rstN         (rstN),
    .enhEn        (enhEn),
    .thrEmptyEvt  (thrEmptyEvt),
    .flowMatch    (flowMatch),
    .specMatch    (specMatch),
    .rxCharStrobe (rxCharStrobe),
    .hsLevel      (hsLevel),
    .clr          (clr),
    .thrFlag      (thrFlag),
    .flowPend     (flowPend),
    .hsFlag       (hsFlag)
  );

  uii_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineErr    (lineErr),
    .rxReady    (rxReady),
    .rxTimeout  (rxTimeout),
    .modemChg   (modemChg),
    .thrFlag    (thrFlag),
    .flowPend   (flowPend),
    .hsFlag     (hsFlag),
    .enhEn      (enhEn),
    .fifoEn     (fifoEn),
    .rdStrobe   (rdStrobe),
    .statusByte (statusByte),
    .intPendN   (intPendN),
    .clr        (clr)
  );

endmodule

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_HS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineErr = 0, rxReady = 0, rxTimeout = 0, thrEmptyEvt = 0, modemChg = 0;
  logic flowMatch = 0, specMatch = 0, rxCharStrobe = 0, fifoEn = 0, enhEn = 0, rdStrobe = 0;
  logic [NUM_HS-1:0] hsLevel = '1;
  logic [7:0] statusByte;
  logic intPendN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model state
  logic mThr = 0, mFlow = 0, mSpec = 0, mHs = 0;
  logic [NUM_HS-1:0] mPrev = '1;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident #(.NUM_HS(NUM_HS)) i_uart_irq_ident (
    .clk(clk), .rstN(rstN), .lineErr(lineErr), .rxReady(rxReady),
    .rxTimeout(rxTimeout), .thrEmptyEvt(thrEmptyEvt), .modemChg(modemChg),
    .flowMatch(flowMatch), .specMatch(specMatch), .hsLevel(hsLevel),
    .rxCharStrobe(rxCharStrobe), .fifoEn(fifoEn), .enhEn(enhEn),
    .rdStrobe(rdStrobe), .statusByte(statusByte), .intPendN(intPendN)
  );

  function automatic logic [5:0] expCode();
    if (lineErr)                       return 6'h06;
    if (rxReady)                       return 6'h04;
    if (rxTimeout)                     return 6'h0C;
    if (mThr)                          return 6'h02;
    if (modemChg)                      return 6'h00;
    if (enhEn && (mFlow || mSpec))     return 6'h10;
    if (enhEn && mHs)                  return 6'h20;
    return 6'h01;
  endfunction

  function automatic logic [7:0] expStatus();
    return {{2{fifoEn}}, expCode()};
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // compare this cycle, then advance the model across one clock edge
  task automatic cyc(string tag);
    logic [5:0] rep;
    #1;
    check8(tag, statusByte, expStatus());
    check8("R9 pending flag", {7'd0, intPendN}, {7'd0, expStatus()[0]});
    rep = expCode();
    @(posedge clk);
    mThr  = thrEmptyEvt | (mThr & !(rdStrobe && rep == 6'h02));
    mFlow = (enhEn & flowMatch) | (mFlow & !(rdStrobe && rep == 6'h10));
    mSpec = (enhEn & specMatch) | (mSpec & !(rdStrobe && rep == 6'h10) & !rxCharStrobe);
    mHs   = (enhEn & (|(hsLevel & ~mPrev))) | (mHs & !(rdStrobe && rep == 6'h20));
    mPrev = hsLevel;
    @(negedge clk);
  endtask

  task automatic quiet();
    lineErr = 0; rxReady = 0; rxTimeout = 0; thrEmptyEvt = 0; modemChg = 0;
    flowMatch = 0; specMatch = 0; rxCharStrobe = 0; rdStrobe = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check8("R1 reset status", statusByte, 8'h01);
    check8("R1 reset pending", {7'd0, intPendN}, 8'h01);
    cyc("R1 idle");
    fifoEn = 1;
    #1 check8("R3 fifo bits", statusByte, 8'hC1);
    cyc("R3 fifo on");
    // R4: events while enhanced disabled are not latched
    flowMatch = 1; specMatch = 1; hsLevel = 2'b10;
    cyc("R4 masked events");
    quiet(); hsLevel = 2'b11;
    cyc("R4 masked rise");
    enhEn = 1;
    #1 check8("R4 nothing latched", statusByte, 8'hC1);
    cyc("R4 enable back");
    // R5: THR flag survives a read reporting a higher source
    thrEmptyEvt = 1; cyc("R5 set");
    thrEmptyEvt = 0;
    #1 check8("R5 thr reported", statusByte, 8'hC2);
    lineErr = 1; rdStrobe = 1; cyc("R5 read hidden");
    lineErr = 0; rdStrobe = 0;
    #1 check8("R5 thr kept", statusByte, 8'hC2);
    rdStrobe = 1;
    #1 check8("R11 read shows source", statusByte, 8'hC2);
    cyc("R11 read");
    rdStrobe = 0;
    #1 check8("R5 thr cleared", statusByte, 8'hC1);
    // R6 flow-control match
    flowMatch = 1; cyc("R6 set"); flowMatch = 0;
    #1 check8("R6 flow reported", statusByte, 8'hD0);
    rxCharStrobe = 1; cyc("R6 char no clear"); rxCharStrobe = 0;
    #1 check8("R6 flow survives char", statusByte, 8'hD0);
    rdStrobe = 1; cyc("R6 read"); rdStrobe = 0;
    #1 check8("R6 flow cleared", statusByte, 8'hC1);
    // R7 special character
    specMatch = 1; cyc("R7 set"); specMatch = 0;
    rxCharStrobe = 1; cyc("R7 char"); rxCharStrobe = 0;
    #1 check8("R7 spec cleared by char", statusByte, 8'hC1);
    specMatch = 1; cyc("R7 set again"); specMatch = 0;
    rdStrobe = 1; cyc("R7 read"); rdStrobe = 0;
    #1 check8("R7 spec cleared by read", statusByte, 8'hC1);
    // R10 set beats clear
    specMatch = 1; rxCharStrobe = 1; cyc("R10 spec+char"); quiet();
    #1 check8("R10 spec set wins", statusByte, 8'hD0);
    rdStrobe = 1; cyc("R10 clear spec"); quiet();
    thrEmptyEvt = 1; cyc("R10 thr set"); thrEmptyEvt = 1; rdStrobe = 1;
    cyc("R10 thr set+read"); quiet();
    #1 check8("R10 thr set wins", statusByte, 8'hC2);
    rdStrobe = 1; cyc("R10 thr clear"); quiet();
    // R8 handshake edges
    hsLevel = 2'b01; cyc("R8 fall");
    #1 check8("R8 fall ignored", statusByte, 8'hC1);
    hsLevel = 2'b11; cyc("R8 rise");
    #1 check8("R8 rise latched", statusByte, 8'hE0);
    modemChg = 1;
    #1 check8("R2 modem above hs", statusByte, 8'hC0);
    check8("R9 modem pending", {7'd0, intPendN}, 8'h00);
    rdStrobe = 1; cyc("R8 read hidden"); quiet();
    #1 check8("R8 hs kept", statusByte, 8'hE0);
    rdStrobe = 1; cyc("R8 read"); quiet();
    #1 check8("R8 hs cleared", statusByte, 8'hC1);
    rxTimeout = 1; thrEmptyEvt = 1;
    #1 check8("R2 timeout code", statusByte, 8'hCC);
    cyc("R2 timeout"); quiet();
    rxReady = 1; #1 check8("R2 rx ready code", statusByte, 8'hC4);
    rdStrobe = 1; cyc("R2 rx ready read"); quiet();
    rdStrobe = 1; cyc("R5 final thr clear"); quiet();
    // R2 constrained random
    for (int i = 0; i < 4000; i++) begin
      lineErr      = ($urandom % 16) == 0;
      rxReady      = ($urandom % 10) == 0;
      rxTimeout    = ($urandom % 16) == 0;
      thrEmptyEvt  = ($urandom % 8) == 0;
      modemChg     = ($urandom % 8) == 0;
      flowMatch    = ($urandom % 16) == 0;
      specMatch    = ($urandom % 16) == 0;
      rxCharStrobe = ($urandom % 6) == 0;
      rdStrobe     = ($urandom % 3) == 0;
      if (($urandom % 6) == 0) hsLevel = hsLevel ^ NUM_HS'($urandom);
      if (($urandom % 40) == 0) enhEn = ~enhEn;
      if (($urandom % 50) == 0) fifoEn = ~fifoEn;
      cyc("R2 random priority");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule